// File: doc/BRIEF.md
# Paged Nonvolatile Byte Store with Staging Buffer

This block is a behavioural model of a byte-addressed nonvolatile memory whose writes pass through a staging buffer as large as one page. A write sequence opens with a start strobe that carries an address. The upper address bits choose the page that will be programmed, and the lower bits give the first buffer offset. Each data strobe after that places one byte at the current offset and then advances the offset. The offset wraps inside the page, so the write never spills into the next page. A stop strobe closes the sequence.

On stop, the block runs an internal programming cycle of fixed length. During that cycle it raises a busy flag, and it ignores new sequences until the cycle is over. At the end of the cycle the page in the array is replaced in one step. Every offset loaded in the latest sequence takes its newest byte, and every other offset keeps what the array already held.

A separate random-access read port returns array contents one cycle after the address is presented. While a page is being programmed, reads still return that page's old contents. The default size is 32 pages of 64 bytes. Setting the page-select width to 8 gives the full 256-page, 16384-byte organisation.

Top module: `pgbuf_eeprom`

## Requirements
- R1: After reset, busy is 0 and every array byte reads as 0xFF.
- R2: A start strobe opens a sequence. The page is taken from wr_addr[10:6] and the starting offset from wr_addr[5:0]. Each wr_valid strobe stores wr_data at the current offset and then increments the offset. On stop, the loaded bytes reach the array at those offsets.
- R3: The offset that follows 63 is offset 0 of the same latched page. No byte ever lands in the next page.
- R4: When one offset is loaded more than once in a sequence, the byte loaded last is the one committed.
- R5: Offsets not loaded in the sequence keep their previous array contents after the commit.
- R6: A start strobe during an open sequence discards every byte loaded before it. Only bytes of the newest sequence are committed.
- R7: After a stop that ends a sequence with at least one loaded byte, busy rises on the next cycle and stays high for exactly COMMIT_CYCLES cycles (default 8). The array shows the new page from the cycle in which busy is low again.
- R8: While busy is high, wr_start, wr_valid and wr_stop have no effect. No further write and no second busy period follow from them.
- R9: A stop with no byte loaded writes nothing and leaves busy at 0.
- R10: rd_data shows the byte at rd_addr one cycle after rd_addr is applied. While busy is high, reads of the page being programmed return its old contents.
- R11: wr_valid and wr_stop strobes that arrive when no sequence is open are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_start | input | 1 | Opens a write sequence at wr_addr |
| wr_addr | input | 11 | Start address: page in [10:6], offset in [5:0] |
| wr_valid | input | 1 | Loads wr_data into the staging buffer |
| wr_data | input | 8 | Data byte to load |
| wr_stop | input | 1 | Closes the sequence and requests the commit |
| rd_addr | input | 11 | Read address |
| rd_data | output | 8 | Byte at the previous cycle's rd_addr |
| busy | output | 1 | High while a page is being programmed |

## Verification
Read data is due one clock edge after the address is applied. Busy is due one edge after the stop strobe and stays high for COMMIT_CYCLES edges. The programmed page becomes visible to a read that is issued once busy has dropped. The bench drives every input on the falling edge and holds it for one full period. It samples on the next falling edge, which is half a period after the edge that produced the result. Busy duration is measured by counting the falling edges at which busy is sampled high.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;

    typedef logic [7:0] byte_t;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_LOAD   = 2'd1,
        SEQ_COMMIT = 2'd2
    } seq_state_e;

endpackage

// File: rtl/pgbuf_stage.sv
// Page-sized staging buffer with a per-byte loaded mask.
module pgbuf_stage
    import pgbuf_pkg::*;
#(
    parameter int OFFSET_W = 6,
    localparam int PAGE_BYTES = 1 << OFFSET_W
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               clr,
    input  logic                               wr_en,
    input  logic [OFFSET_W-1:0]                wr_off,
    input  byte_t                              wr_byte,
    output logic [PAGE_BYTES-1:0][7:0]         stage_bytes,
    output logic [PAGE_BYTES-1:0]              stage_mask,
    output logic                               any_loaded
);

    typedef struct packed {
        logic [PAGE_BYTES-1:0][7:0] bytes;
        logic [PAGE_BYTES-1:0]      mask;
    } stage_t;

    stage_t stage_d, stage_q;

    always_comb begin
        stage_d = stage_q;
        if (clr) begin
            stage_d.mask = '0;
        end else if (wr_en) begin
            stage_d.bytes[wr_off] = wr_byte;
            stage_d.mask[wr_off]  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign stage_bytes = stage_q.bytes;
    assign stage_mask  = stage_q.mask;
    assign any_loaded  = |stage_q.mask;

endmodule

// File: rtl/pgbuf_ctrl.sv
// Sequence controller: latches the page, walks the wrapping offset and
// times the programming cycle.
module pgbuf_ctrl
    import pgbuf_pkg::*;
#(
    parameter int PAGE_SEL_W    = 5,
    parameter int OFFSET_W      = 6,
    parameter int COMMIT_CYCLES = 8,
    localparam int ADDR_W = PAGE_SEL_W + OFFSET_W,
    localparam int CNT_W  = $clog2(COMMIT_CYCLES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_start,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic                  wr_valid,
    input  logic                  wr_stop,
    input  logic                  any_loaded,
    output logic                  stage_clr,
    output logic                  stage_wr,
    output logic [OFFSET_W-1:0]   stage_off,
    output logic                  commit_fire,
    output logic [PAGE_SEL_W-1:0] commit_page,
    output logic                  busy
);

    localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(COMMIT_CYCLES - 1);

    typedef struct packed {
        seq_state_e            st;
        logic [PAGE_SEL_W-1:0] page;
        logic [OFFSET_W-1:0]   off;
        logic [CNT_W-1:0]      cnt;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  clr_d, wr_d, fire_d;

    always_comb begin
        ctrl_d = ctrl_q;
        clr_d  = 1'b0;
        wr_d   = 1'b0;
        fire_d = 1'b0;
        unique case (ctrl_q.st)
            SEQ_IDLE: begin
                if (wr_start) begin
                    ctrl_d.st   = SEQ_LOAD;
                    ctrl_d.page = wr_addr[ADDR_W-1:OFFSET_W];
                    ctrl_d.off  = wr_addr[OFFSET_W-1:0];
                    clr_d       = 1'b1;
                end
            end
            SEQ_LOAD: begin
                if (wr_start) begin
                    ctrl_d.page = wr_addr[ADDR_W-1:OFFSET_W];
                    ctrl_d.off  = wr_addr[OFFSET_W-1:0];
                    clr_d       = 1'b1;
                end else if (wr_stop) begin
                    if (any_loaded) begin
                        ctrl_d.st  = SEQ_COMMIT;
                        ctrl_d.cnt = CNT_INIT;
                    end else begin
                        ctrl_d.st = SEQ_IDLE;
                    end
                end else if (wr_valid) begin
                    wr_d       = 1'b1;
                    ctrl_d.off = ctrl_q.off + 1'b1;
                end
            end
            SEQ_COMMIT: begin
                if (ctrl_q.cnt == '0) begin
                    fire_d    = 1'b1;
                    ctrl_d.st = SEQ_IDLE;
                end else begin
                    ctrl_d.cnt = ctrl_q.cnt - 1'b1;
                end
            end
            default: ctrl_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '{st: SEQ_IDLE, page: '0, off: '0, cnt: '0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign stage_clr   = clr_d;
    assign stage_wr    = wr_d;
    assign stage_off   = ctrl_q.off;
    assign commit_fire = fire_d;
    assign commit_page = ctrl_q.page;
    assign busy        = (ctrl_q.st == SEQ_COMMIT);

endmodule

// File: rtl/pgbuf_array.sv
// Page-organised storage: whole-page merged write, registered byte read.
module pgbuf_array
    import pgbuf_pkg::*;
#(
    parameter int PAGE_SEL_W = 5,
    parameter int OFFSET_W   = 6,
    localparam int PAGES      = 1 << PAGE_SEL_W,
    localparam int PAGE_BYTES = 1 << OFFSET_W,
    localparam int ADDR_W     = PAGE_SEL_W + OFFSET_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       commit_fire,
    input  logic [PAGE_SEL_W-1:0]      commit_page,
    input  logic [PAGE_BYTES-1:0][7:0] stage_bytes,
    input  logic [PAGE_BYTES-1:0]      stage_mask,
    input  logic [ADDR_W-1:0]          rd_addr,
    output byte_t                      rd_data
);

    logic [PAGE_BYTES-1:0][7:0] cells [PAGES];
    logic [PAGE_BYTES-1:0][7:0] old_page;
    logic [PAGE_BYTES-1:0][7:0] merged_page;
    logic [PAGE_BYTES-1:0][7:0] rd_page;
    byte_t                      rd_d, rd_q;

    assign old_page = cells[commit_page];

    for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_merge
        assign merged_page[i] = stage_mask[i] ? stage_bytes[i] : old_page[i];
    end

    assign rd_page = cells[rd_addr[ADDR_W-1:OFFSET_W]];

    always_comb begin
        rd_d = rd_page[rd_addr[OFFSET_W-1:0]];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < PAGES; p++) begin
                cells[p] <= '1;
            end
            rd_q <= '1;
        end else begin
            if (commit_fire) begin
                cells[commit_page] <= merged_page;
            end
            rd_q <= rd_d;
        end
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/pgbuf_eeprom.sv
module pgbuf_eeprom
    import pgbuf_pkg::*;
#(
    parameter int PAGE_SEL_W    = 5,
    parameter int OFFSET_W      = 6,
    parameter int COMMIT_CYCLES = 8,
    localparam int ADDR_W     = PAGE_SEL_W + OFFSET_W,
    localparam int PAGE_BYTES = 1 << OFFSET_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_start,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_valid,
    input  logic [7:0]        wr_data,
    input  logic              wr_stop,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy
);

    logic                       stage_clr, stage_wr, any_loaded, commit_fire;
    logic [OFFSET_W-1:0]        stage_off;
    logic [PAGE_SEL_W-1:0]      commit_page;
    logic [PAGE_BYTES-1:0][7:0] stage_bytes;
    logic [PAGE_BYTES-1:0]      stage_mask;

    pgbuf_ctrl #(
        .PAGE_SEL_W   (PAGE_SEL_W),
        .OFFSET_W     (OFFSET_W),
        .COMMIT_CYCLES(COMMIT_CYCLES)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_start   (wr_start),
        .wr_addr    (wr_addr),
        .wr_valid   (wr_valid),
        .wr_stop    (wr_stop),
        .any_loaded (any_loaded),
        .stage_clr  (stage_clr),
        .stage_wr   (stage_wr),
        .stage_off  (stage_off),
        .commit_fire(commit_fire),
        .commit_page(commit_page),
        .busy       (busy)
    );

    pgbuf_stage #(
        .OFFSET_W(OFFSET_W)
    ) u_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (stage_clr),
        .wr_en      (stage_wr),
        .wr_off     (stage_off),
        .wr_byte    (wr_data),
        .stage_bytes(stage_bytes),
        .stage_mask (stage_mask),
        .any_loaded (any_loaded)
    );

    pgbuf_array #(
        .PAGE_SEL_W(PAGE_SEL_W),
        .OFFSET_W  (OFFSET_W)
    ) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_fire(commit_fire),
        .commit_page(commit_page),
        .stage_bytes(stage_bytes),
        .stage_mask (stage_mask),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data)
    );

endmodule

// File: rtl/pgbuf_chk.sv
module pgbuf_chk #(
    parameter int ADDR_W        = 11,
    parameter int COMMIT_CYCLES = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_stop,
    input logic              busy,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [7:0]        rd_data
);

    int unsigned busy_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_run <= 0;
        end else if (busy) begin
            busy_run <= busy_run + 1;
        end else begin
            busy_run <= 0;
        end
    end

    // R2 / R9: a programming cycle only ever starts from a stop strobe
    assert_busy_from_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_stop));

    // R7: busy ends exactly after COMMIT_CYCLES cycles
    assert_busy_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_run == COMMIT_CYCLES));

    // R7 / R8: busy cannot end early, whatever arrives on the write port
    assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (busy_run < COMMIT_CYCLES - 1)) |=> busy);

    // R10: array content seen by reads is frozen during programming
    assert_read_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && $stable(rd_addr)) |=> $stable(rd_data));

endmodule

bind pgbuf_eeprom pgbuf_chk #(
    .ADDR_W       (ADDR_W),
    .COMMIT_CYCLES(COMMIT_CYCLES)
) u_pgbuf_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_stop(wr_stop),
    .busy   (busy),
    .rd_addr(rd_addr),
    .rd_data(rd_data)
);

// File: tb/test_pgbuf_eeprom.sv
`timescale 1ns/1ps
module test_pgbuf_eeprom;

    localparam int AW = 11;
    localparam int CC = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_start = 1'b0, wr_valid = 1'b0, wr_stop = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [7:0]    rd_data;
    logic          busy;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    pgbuf_eeprom #(.PAGE_SEL_W(5), .OFFSET_W(6), .COMMIT_CYCLES(CC)) i_pgbuf_eeprom (
        .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_addr(wr_addr),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_stop(wr_stop),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
    );

    typedef struct packed {
        logic [15:0] addr;
        logic [7:0]  exp;
        logic [7:0]  req;
    } vec_t;

    // Read-back table after sequences A, B and C (see main flow)
    localparam vec_t VEC [12] = '{
        '{16'd252, 8'h10, 8'd2},  // R2: page 3 offset 60
        '{16'd253, 8'h11, 8'd2},
        '{16'd254, 8'h12, 8'd2},
        '{16'd255, 8'h13, 8'd3},  // R3: offset 63
        '{16'd192, 8'h14, 8'd3},  // R3: wrapped to offset 0 of page 3
        '{16'd193, 8'h77, 8'd5},  // R5: sequence C byte
        '{16'd194, 8'hFF, 8'd5},  // R5: untouched offset
        '{16'd256, 8'hFF, 8'd3},  // R3: next page untouched
        '{16'd322, 8'h40, 8'd4},  // R4: last byte at offset 2 wins
        '{16'd323, 8'h01, 8'd4},
        '{16'd321, 8'h3F, 8'd4},
        '{16'd320, 8'h3E, 8'd4}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_start(input int a);
        wr_start = 1'b1; wr_addr = AW'(a);
        @(negedge clk);
        wr_start = 1'b0;
    endtask

    task automatic do_put(input logic [7:0] d);
        wr_valid = 1'b1; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic do_stop();
        wr_stop = 1'b1;
        @(negedge clk);
        wr_stop = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic do_read(input int a, output logic [7:0] d);
        rd_addr = AW'(a);
        @(negedge clk);
        d = rd_data;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 busy", {7'd0, busy}, 8'd0);
        do_read(0, d);    check("R1 addr0", d, 8'hFF);
        do_read(2047, d); check("R1 last", d, 8'hFF);

        // Sequence A: page 3 offset 60, six bytes wrap (R2, R3); busy timing (R7)
        do_start(252);
        for (int i = 0; i < 6; i++) do_put(8'h10 + 8'(i));
        do_stop();
        check("R7 busy rise", {7'd0, busy}, 8'd1);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        check("R7 busy length", 8'(n), 8'(CC));

        // Sequence B: 65 bytes from page 5 offset 2 (R4)
        do_start(322);
        for (int i = 0; i < 65; i++) do_put(8'(i));
        do_stop();
        wait_idle();

        // Sequence C: one byte to page 3 offset 1 (R5)
        do_start(193);
        do_put(8'h77);
        do_stop();
        wait_idle();

        foreach (VEC[i]) begin
            do_read(int'(VEC[i].addr), d);
            check($sformatf("R%0d table %0d", VEC[i].req, i), d, VEC[i].exp);
        end

        // Sequence D: R10 old data while busy, R8 write port ignored while busy
        do_start(448);
        do_put(8'h55);
        do_stop();
        do_read(448, d);
        check("R10 old during busy", d, 8'hFF);
        do_start(512);
        do_put(8'h99);
        do_stop();
        wait_idle();
        do_read(448, d);
        check("R10 new after busy", d, 8'h55);
        check("R8 no second busy", {7'd0, busy}, 8'd0);
        do_read(512, d);
        check("R8 ignored write", d, 8'hFF);

        // R9: stop with nothing loaded
        do_start(600);
        do_stop();
        check("R9 busy stays low", {7'd0, busy}, 8'd0);

        // R6: restart discards earlier bytes
        do_start(640);
        do_put(8'h21);
        do_start(700);
        do_put(8'h22);
        do_stop();
        wait_idle();
        do_read(640, d); check("R6 discarded", d, 8'hFF);
        do_read(700, d); check("R6 kept", d, 8'h22);

        // R11: strobes with no open sequence
        do_put(8'h33);
        do_stop();
        check("R11 busy low", {7'd0, busy}, 8'd0);
        do_read(701, d); check("R11 no write", d, 8'hFF);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule